// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the device-side command interpreter of a byte-wide parallel flash model. It watches write bus cycles and recognises the multi-write unlock sequences. These sequences request a byte program, a whole-array erase, a sector erase, entry into identifier mode, or a return to plain array reads. The memory array, the operation timing and the status reporting are handled by other blocks.

Every write is one clock cycle with `wr_en_i` high. A sequence step counter moves forward only when the write carries the exact address and data pair that the next step expects. When the final write of a sequence is sampled, the same clock edge raises a one-cycle start pulse for the operation. That edge also latches the target address, the final data byte and the sector number. The operation engine raises `busy_i` while it works, and every write is ignored for that time. The read path returns either the array byte supplied from outside or one of two identifier bytes.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, no start pulse is high, `id_mode_o` is 0, and `rd_data_o` equals `array_data_i`.
- R2: Command addresses are matched on the low 15 address bits only. Key address A is 0x5555 and key address B is 0x2AAA. An unlock pair is 0xAA written to A, followed by 0x55 written to B. Address bit 16 is ignored in this match.
- R3: Byte program is an unlock pair, then 0xA0 written to A, then a fourth write of any address and data. The fourth write raises `prog_start_o`. `op_addr_o` then holds the full address of that write and `op_data_o` holds its data.
- R4: Whole-array erase is an unlock pair, then 0x80 written to A, then a second unlock pair, then 0x10 written to A. The last write raises `chip_erase_start_o`.
- R5: Sector erase uses the same first five writes as R4, then 0x30 written to any address. That write raises `sector_erase_start_o`. `sector_o` then holds address bits [16:15] of that write, `op_addr_o` holds its address and `op_data_o` holds 0x30.
- R6: An unlock pair followed by 0x90 written to A sets `id_mode_o`. In identifier mode, a read at offset 0 returns 0x40. A read at offset 1 returns 0x01 with `BOOT_TOP`=1 (the default) or 0xA1 with `BOOT_TOP`=0. Any other offset returns 0x00.
- R7: A write of 0xF0 at any address, or an unlock pair followed by 0xF0 written to A, clears `id_mode_o` and restores array reads.
- R8: A write that does not match the expected step returns the sequence to its start and clears `id_mode_o`. A mismatched write never restarts a sequence by itself.
- R9: While `busy_i` is high, writes have no effect: no pulse, no step change and no change to `id_mode_o`.
- R10: Start pulses last exactly one cycle, at most one is high at a time, and they occur only on the edge that samples a sequence's final write.
- R11: `op_addr_o`, `op_data_o` and `sector_o` hold their values until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one cycle per bus write |
| addr_i | input | ADDR_W | Write address |
| wdata_i | input | 8 | Write data |
| busy_i | input | 1 | Operation engine busy; writes ignored |
| rd_addr_i | input | ADDR_W | Read address |
| array_data_i | input | 8 | Byte from the memory array |
| rd_data_o | output | 8 | Read data returned to the bus |
| id_mode_o | output | 1 | Identifier read mode active |
| prog_start_o | output | 1 | Byte program start pulse |
| chip_erase_start_o | output | 1 | Whole-array erase start pulse |
| sector_erase_start_o | output | 1 | Sector erase start pulse |
| op_addr_o | output | ADDR_W | Address latched at launch |
| op_data_o | output | 8 | Data latched at launch |
| sector_o | output | ADDR_W-CMP_W | Sector number latched at launch |

## Verification
The engine's busy flag can coincide with the write that would complete a sequence. The bench provokes this by holding `busy_i` high across the fourth program write and across a bare 0xF0 write. It judges the result at the ports: no start pulse appears, `id_mode_o` keeps its value, and repeating the fourth write after busy drops launches the program. This shows that the step was held and not discarded. A read in identifier mode can also coincide with the write that leaves the mode. The bench checks that reads return identifier bytes up to that write and array data from the following cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_U1, ST_U2, ST_PROG, ST_E1, ST_E2, ST_E3
  } step_e;

  typedef enum logic [1:0] {
    OP_NONE, OP_PROG, OP_CHIP, OP_SECT
  } op_e;

  localparam logic [7:0] D_UNLK1 = 8'hAA;
  localparam logic [7:0] D_UNLK2 = 8'h55;
  localparam logic [7:0] D_PROG  = 8'hA0;
  localparam logic [7:0] D_ERSU  = 8'h80;
  localparam logic [7:0] D_IDENT = 8'h90;
  localparam logic [7:0] D_RST   = 8'hF0;
  localparam logic [7:0] D_CHIP  = 8'h10;
  localparam logic [7:0] D_SECT  = 8'h30;
  localparam logic [7:0] ID_MFR  = 8'h40;
  localparam logic [7:0] ID_TOP  = 8'h01;
  localparam logic [7:0] ID_BOT  = 8'hA1;
endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int CMP_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             busy_i,
  input  logic [CMP_W-1:0] addr_lo_i,
  input  logic [7:0]       wdata_i,
  output op_e              launch_o,
  output logic             id_mode_o
);
  localparam logic [CMP_W-1:0] KEY_A = CMP_W'(32'h5555);
  localparam logic [CMP_W-1:0] KEY_B = CMP_W'(32'h2AAA);

  step_e step_q, step_d;
  logic  id_q, id_d;
  logic  at_a, at_b, wr_ok;

  assign at_a  = (addr_lo_i == KEY_A);
  assign at_b  = (addr_lo_i == KEY_B);
  assign wr_ok = wr_en_i && !busy_i;

  always_comb begin
    step_d   = step_q;
    id_d     = id_q;
    launch_o = OP_NONE;
    if (wr_ok) begin
      // default: abort to start, back to array reads
      step_d = ST_IDLE;
      id_d   = 1'b0;
      case (step_q)
        ST_IDLE: if (at_a && wdata_i == D_UNLK1) begin step_d = ST_U1; id_d = id_q; end
        ST_U1:   if (at_b && wdata_i == D_UNLK2) begin step_d = ST_U2; id_d = id_q; end
        ST_U2: begin
          if (at_a && wdata_i == D_PROG) begin
            step_d = ST_PROG; id_d = id_q;
          end else if (at_a && wdata_i == D_ERSU) begin
            step_d = ST_E1; id_d = id_q;
          end else if (at_a && wdata_i == D_IDENT) begin
            id_d = 1'b1;
          end
        end
        ST_PROG: launch_o = OP_PROG;
        ST_E1:   if (at_a && wdata_i == D_UNLK1) begin step_d = ST_E2; id_d = id_q; end
        ST_E2:   if (at_b && wdata_i == D_UNLK2) begin step_d = ST_E3; id_d = id_q; end
        ST_E3: begin
          if (at_a && wdata_i == D_CHIP)  launch_o = OP_CHIP;
          else if (wdata_i == D_SECT)     launch_o = OP_SECT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IDLE;
      id_q   <= 1'b0;
    end else begin
      step_q <= step_d;
      id_q   <= id_d;
    end
  end

  assign id_mode_o = id_q;

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && busy_i) |=> ($stable(step_q) && $stable(id_q)));

  // R8
  id_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(id_q) && $stable(step_q)));

  // R6
  id_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && step_q == ST_U2 && at_a && wdata_i == D_IDENT) |=> id_q);
endmodule

// File: rtl/flash_cmd_launch.sv
module flash_cmd_launch
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CMP_W  = 15,
  localparam int SECT_W = ADDR_W - CMP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               launch_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              prog_o,
  output logic              chip_o,
  output logic              sect_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [7:0]        op_data_o,
  output logic [SECT_W-1:0] sector_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_o    <= 1'b0;
      chip_o    <= 1'b0;
      sect_o    <= 1'b0;
      op_addr_o <= '0;
      op_data_o <= '0;
      sector_o  <= '0;
    end else begin
      prog_o <= (launch_i == OP_PROG);
      chip_o <= (launch_i == OP_CHIP);
      sect_o <= (launch_i == OP_SECT);
      if (launch_i != OP_NONE) begin
        op_addr_o <= addr_i;
        op_data_o <= wdata_i;
        sector_o  <= addr_i[ADDR_W-1:CMP_W];
      end
    end
  end

  // R10
  launch_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_o, chip_o, sect_o}));

  // R10
  launch_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_o || chip_o || sect_o) |=> !(prog_o || chip_o || sect_o));

  // R11
  op_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_i == OP_NONE) |=> ($stable(op_addr_o) && $stable(op_data_o) && $stable(sector_o)));
endmodule

// File: rtl/flash_id_mux.sv
module flash_id_mux
  import flash_cmd_pkg::*;
#(
  parameter int   ADDR_W   = 17,
  parameter int   CMP_W    = 15,
  parameter logic BOOT_TOP = 1'b1
) (
  input  logic              id_mode_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [7:0]        array_data_i,
  output logic [7:0]        rd_data_o
);
  logic [7:0] dev_code, id_byte;
  logic [CMP_W-1:0] ofs;

  generate
    if (BOOT_TOP) begin : g_top
      assign dev_code = ID_TOP;
    end else begin : g_bot
      assign dev_code = ID_BOT;
    end
  endgenerate

  assign ofs = rd_addr_i[CMP_W-1:0];

  always_comb begin
    if (ofs == CMP_W'(0))      id_byte = ID_MFR;
    else if (ofs == CMP_W'(1)) id_byte = dev_code;
    else                       id_byte = 8'h00;
  end

  assign rd_data_o = id_mode_i ? id_byte : array_data_i;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int   ADDR_W   = 17,
  parameter int   CMP_W    = 15,
  parameter logic BOOT_TOP = 1'b1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [7:0]                wdata_i,
  input  logic                      busy_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  input  logic [7:0]                array_data_i,
  output logic [7:0]                rd_data_o,
  output logic                      id_mode_o,
  output logic                      prog_start_o,
  output logic                      chip_erase_start_o,
  output logic                      sector_erase_start_o,
  output logic [ADDR_W-1:0]         op_addr_o,
  output logic [7:0]                op_data_o,
  output logic [ADDR_W-CMP_W-1:0]   sector_o
);
  op_e launch;

  flash_cmd_seq #(.CMP_W(CMP_W)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .busy_i    (busy_i),
    .addr_lo_i (addr_i[CMP_W-1:0]),
    .wdata_i   (wdata_i),
    .launch_o  (launch),
    .id_mode_o (id_mode_o)
  );

  flash_cmd_launch #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) i_launch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .prog_o    (prog_start_o),
    .chip_o    (chip_erase_start_o),
    .sect_o    (sector_erase_start_o),
    .op_addr_o (op_addr_o),
    .op_data_o (op_data_o),
    .sector_o  (sector_o)
  );

  flash_id_mux #(.ADDR_W(ADDR_W), .CMP_W(CMP_W), .BOOT_TOP(BOOT_TOP)) i_mux (
    .id_mode_i    (id_mode_o),
    .rd_addr_i    (rd_addr_i),
    .array_data_i (array_data_i),
    .rd_data_o    (rd_data_o)
  );

  // R10
  no_stray_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && !busy_i) |=> !(prog_start_o || chip_erase_start_o || sector_erase_start_o));
endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  localparam int AW = 17;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    wdata_i = '0;
  logic          busy_i = 1'b0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [7:0]    array_data_i = 8'h5A;
  logic [7:0]    rd_data_o;
  logic          id_mode_o, prog_start_o, chip_erase_start_o, sector_erase_start_o;
  logic [AW-1:0] op_addr_o;
  logic [7:0]    op_data_o;
  logic [1:0]    sector_o;

  flash_cmd_decoder i_flash_cmd_decoder (.*);

  always #10 clk_i = ~clk_i;

  typedef struct {
    int         kind;
    logic [AW-1:0] a;
    logic [7:0] d;
    logic [1:0] s;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int vectors = 0;
  int miscompares = 0;
  bit prev_pulse = 0;

  function automatic void fail(string tag, string what, int act, int exp);
    miscompares++;
    $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
  endfunction

  function automatic void chk(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) fail(tag, what, act, exp);
  endfunction

  task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic unlock();
    bus_wr(17'h05555, 8'hAA);
    bus_wr(17'h02AAA, 8'h55);
  endtask

  task automatic expect_op(int kind, logic [AW-1:0] a, logic [7:0] d, logic [1:0] s, string tag);
    exp_t e;
    e.kind = kind; e.a = a; e.d = d; e.s = s; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic rd_chk(logic [AW-1:0] a, logic [7:0] exp, string tag);
    @(negedge clk_i);
    rd_addr_i = a;
    #2;
    chk(tag, "rd_data", int'(rd_data_o), int'(exp));
  endtask

  // monitor: scoreboard of start pulses
  initial begin
    forever begin
      @(posedge clk_i); #5;
      if (rst_ni && (prog_start_o || chip_erase_start_o || sector_erase_start_o)) begin
        int kind;
        vectors++;
        kind = prog_start_o ? 1 : chip_erase_start_o ? 2 : 3;
        if ($countones({prog_start_o, chip_erase_start_o, sector_erase_start_o}) > 1)
          fail("R10", "multiple pulses", 1, 0);
        if (prev_pulse) fail("R10", "pulse width", 2, 1);
        if (exp_q.size() == 0) begin
          fail("R8/R9/R10", "unexpected launch kind", kind, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (kind != e.kind) fail(e.tag, "launch kind", kind, e.kind);
          if (op_addr_o != e.a) fail(e.tag, "op_addr", int'(op_addr_o), int'(e.a));
          if (op_data_o != e.d) fail(e.tag, "op_data", int'(op_data_o), int'(e.d));
          if (kind == 3 && sector_o != e.s) fail(e.tag, "sector", int'(sector_o), int'(e.s));
        end
        prev_pulse = 1;
      end else begin
        prev_pulse = 0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk_i);
    fail("WDOG", "timeout", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "prog_start", int'(prog_start_o), 0);
    chk("R1", "id_mode", int'(id_mode_o), 0);
    rst_ni = 1'b1;
    rd_chk(17'h00000, 8'h5A, "R1");
    chk("R1", "pulses", int'({prog_start_o, chip_erase_start_o, sector_erase_start_o}), 0);

    // R3 program, with R2 address bit 16 ignored on the first key write
    bus_wr(17'h15555, 8'hAA);
    bus_wr(17'h02AAA, 8'h55);
    bus_wr(17'h05555, 8'hA0);
    expect_op(1, 17'h12345, 8'h3C, 2'd0, "R3");
    bus_wr(17'h12345, 8'h3C);

    // R4 whole-array erase
    unlock(); bus_wr(17'h05555, 8'h80);
    unlock();
    expect_op(2, 17'h05555, 8'h10, 2'd0, "R4");
    bus_wr(17'h05555, 8'h10);

    // R5 sector erase
    unlock(); bus_wr(17'h05555, 8'h80);
    unlock();
    expect_op(3, 17'h18000, 8'h30, 2'd3, "R5");
    bus_wr(17'h18000, 8'h30);

    // R6 identifier mode
    unlock(); bus_wr(17'h05555, 8'h90);
    chk("R6", "id_mode", int'(id_mode_o), 1);
    rd_chk(17'h00000, 8'h40, "R6");
    rd_chk(17'h00001, 8'h01, "R6");
    rd_chk(17'h00002, 8'h00, "R6");

    // R7 bare reset write at any address
    bus_wr(17'h00123, 8'hF0);
    chk("R7", "id_mode", int'(id_mode_o), 0);
    rd_chk(17'h00000, 8'h5A, "R7");
    // R11 latched values still from the sector erase
    chk("R11", "op_addr hold", int'(op_addr_o), 'h18000);
    chk("R11", "op_data hold", int'(op_data_o), 'h30);
    chk("R11", "sector hold", int'(sector_o), 3);

    // R7 unlocked reset
    unlock(); bus_wr(17'h05555, 8'h90);
    unlock();
    chk("R7", "id kept during unlock", int'(id_mode_o), 1);
    bus_wr(17'h05555, 8'hF0);
    chk("R7", "id_mode", int'(id_mode_o), 0);

    // R8 mismatch clears identifier mode
    unlock(); bus_wr(17'h05555, 8'h90);
    bus_wr(17'h05555, 8'h12);
    chk("R8", "id_mode", int'(id_mode_o), 0);
    // R8 wrong address for A0 aborts, fourth write must not launch
    unlock(); bus_wr(17'h02AAA, 8'hA0);
    bus_wr(17'h00777, 8'h11);
    // R8 repeated AA aborts, no restart
    bus_wr(17'h05555, 8'hAA);
    bus_wr(17'h05555, 8'hAA);
    bus_wr(17'h02AAA, 8'h55);
    bus_wr(17'h05555, 8'hA0);
    bus_wr(17'h00777, 8'h22);
    chk("R8", "no launch after aborts", exp_q.size(), 0);

    // R9 busy coincides with the final program write and a bare reset
    unlock(); bus_wr(17'h05555, 8'hA0);
    @(negedge clk_i); busy_i = 1'b1;
    bus_wr(17'h00ABC, 8'h77);
    bus_wr(17'h00000, 8'hF0);
    @(negedge clk_i); busy_i = 1'b0;
    expect_op(1, 17'h00ABC, 8'h99, 2'd0, "R9");
    bus_wr(17'h00ABC, 8'h99);
    // R9 busy leaves identifier mode untouched
    unlock(); bus_wr(17'h05555, 8'h90);
    @(negedge clk_i); busy_i = 1'b1;
    bus_wr(17'h00000, 8'hF0);
    chk("R9", "id_mode under busy", int'(id_mode_o), 1);
    @(negedge clk_i); busy_i = 1'b0;
    // R6 read coincides with exit write
    @(negedge clk_i);
    rd_addr_i = 17'h00000; wr_en_i = 1'b1; addr_i = 17'h00000; wdata_i = 8'hF0;
    #2; chk("R6", "id read before exit edge", int'(rd_data_o), 'h40);
    @(negedge clk_i); wr_en_i = 1'b0;
    #2; chk("R7", "array read after exit", int'(rd_data_o), 'h5A);

    repeat (4) @(negedge clk_i);
    chk("R10", "pending launches", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule